// File: doc/BRIEF.md
# Accumulator Window Extractor with Rounding and Saturation

This unit reduces a 64-bit signed accumulator to a 32-bit signed word. A small signed cut point picks which 32-bit window of the accumulator becomes the result. Conceptually the accumulator is first sign-extended to 128 bits. The window's top bit then sits at position (63 − cut point) of that extended value. When the window drops low-order bits, the result is rounded half-up. If the value does not fit in 32 signed bits, the result clamps to the nearest limit.

A cut point below zero pre-scales the accumulator down by an arithmetic right shift. The shifted value is then treated as a cut point of zero, so rounding still applies.

The unit is a single-stage datapath. A caller presents an accumulator and an operand word together with a valid strobe. The registered result and a valid flag appear on the next rising clock edge. The result register keeps its last value while no new request arrives.

Top module: `acc_cut_round`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a rising edge at which `in_valid` was sampled high (one-cycle latency, back-to-back requests allowed).
- R2: A rising edge with `rst_n` low clears `out_valid` to 0 and `out_word` to 0.
- R3: A rising edge with `in_valid` low leaves `out_word` unchanged, whatever `acc_in` and `cut_op` hold.
- R4: The cut point is `cut_op[6:0]`, read as a two's-complement value c in −64..63. Bits `cut_op[31:7]` have no effect on the result.
- R5: For c in 0..63, an unsaturated result equals bits (63−c) down to (32−c) of the 128-bit sign extension of `acc_in`. A bit index below 0 reads as 0.
- R6: For c in 0..31, the result is incremented when bit (31−c) of `acc_in` is 1 (round half-up). Rounding the largest positive value upward yields 0x7FFFFFFF, and rounding −0.5 of an LSB yields 0.
- R7: For c < 0, `acc_in` is first shifted arithmetically right by −c (by 63 when c = −64). The result is then formed as for c = 0, including the rounding of R6.
- R8: If the exact windowed value exceeds 0x7FFFFFFF, the result is 0x7FFFFFFF. If it is below −2^31, the result is 0x80000000.
- R9: An accumulator of zero gives a result of zero for every cut point.
- R10: A non-negative accumulator never gives a negative result, and a negative accumulator never gives a positive result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| acc_in | input | 64 | Signed accumulator value |
| cut_op | input | 32 | Operand word; low 7 bits hold the signed cut point |
| out_valid | output | 1 | High for one cycle per accepted request |
| out_word | output | 32 | Registered rounded and saturated result |

## Verification
The hardest situations to reach are the ones where rounding and clamping interact. One case is an accumulator whose truncated window is exactly 0x7FFFFFFF while the first discarded bit is set. The other is a truncated window of −1 that rounds up to 0. Random accumulators essentially never hit these at a given cut point. So, for every cut point from 0 to 31, the stimulus builds the accumulator bit by bit: it places the all-ones positive pattern just above the half-LSB position, and separately a lone negative half-LSB. Negative cut points are swept over extreme accumulators so that the pre-shift path and its clamp at −64 are driven together with the rounding.

// File: rtl/acc_cut_pkg.sv
// Package: acc_cut_pkg
// Shared constants and the saturation class type for the accumulator
// window extractor. Assumes a two's-complement datapath throughout.
package acc_cut_pkg;

    // Default widths of the datapath.
    localparam int ACC_W_DEF = 64;
    localparam int OUT_W_DEF = 32;
    localparam int CUT_W_DEF = 7;
    localparam int OP_W_DEF  = 32;

    // Outcome of the range check on the bits above the output window.
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_POS  = 2'd1,
        SAT_NEG  = 2'd2
    } sat_class_e;

endpackage

// File: rtl/acc_cut_decode.sv
// Module: acc_cut_decode
// Extracts the signed cut point from the operand word and applies the
// pre-scale for negative cut points. Output cut_pos is the effective,
// non-negative cut point; acc_adj is the possibly right-shifted
// accumulator. Assumes CUT_W-1 bits are enough to index ACC_W.
module acc_cut_decode #(
    parameter int ACC_W = 64,
    parameter int OP_W  = 32,
    parameter int CUT_W = 7
) (
    input  logic [OP_W-1:0]  cut_op,
    input  logic [ACC_W-1:0] acc_in,
    output logic [CUT_W-2:0] cut_pos,
    output logic [ACC_W-1:0] acc_adj
);
    localparam int SH_W   = $clog2(ACC_W);
    localparam int MAX_SH = ACC_W - 1;

    logic signed [CUT_W-1:0] cut_s;
    logic [CUT_W-1:0]        mag;
    logic [SH_W-1:0]         pre_sh;
    logic signed [ACC_W-1:0] acc_s;
    logic                    unused_op_hi;

    assign cut_s        = cut_op[CUT_W-1:0];
    assign unused_op_hi = ^cut_op[OP_W-1:CUT_W];
    assign acc_s        = acc_in;

    // Magnitude of a negative cut point, clamped to the widest legal shift.
    always_comb begin
        mag = -cut_s;
        if (!cut_s[CUT_W-1]) begin
            pre_sh = '0;
        end else if (int'(mag) > MAX_SH) begin
            pre_sh = SH_W'(MAX_SH);
        end else begin
            pre_sh = SH_W'(mag);
        end
    end

    // Pre-scaled accumulator and the cut point that follows it.
    always_comb begin
        acc_adj = acc_s >>> pre_sh;
        cut_pos = cut_s[CUT_W-1] ? '0 : cut_s[CUT_W-2:0];
    end

endmodule

// File: rtl/acc_cut_round_path.sv
// Module: acc_cut_round_path
// Window path for cut points below OUT_W. The accumulator is shifted
// right, dropping its low bits, and rounded half-up from the first
// dropped bit. The increment is skipped once the candidate has reached
// the positive limit. Outputs are valid only when the cut point is below
// OUT_W; otherwise the shift amounts are held at zero.
module acc_cut_round_path #(
    parameter int ACC_W = 64,
    parameter int OUT_W = 32,
    parameter int CUT_W = 7
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [CUT_W-2:0] cut_pos,
    output logic [OUT_W-1:0] low_word,
    output logic [ACC_W-1:0] upper
);
    localparam int RA_W = $clog2(OUT_W + 1);
    localparam int IX_W = $clog2(ACC_W);
    localparam logic signed [ACC_W-1:0] POS_MAX =
        {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};

    logic                    active;
    logic [RA_W-1:0]         r_amt;
    logic [IX_W-1:0]         rb_idx;
    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] cand;
    logic signed [ACC_W-1:0] cand_r;
    logic                    do_round;

    assign acc_s  = acc;
    assign active = int'(cut_pos) < OUT_W;

    // Shift distance and position of the half-LSB bit for this cut.
    always_comb begin
        if (active) begin
            r_amt  = RA_W'(OUT_W - int'(cut_pos));
            rb_idx = IX_W'(OUT_W - 1 - int'(cut_pos));
        end else begin
            r_amt  = '0;
            rb_idx = '0;
        end
    end

    // Truncate, round half-up below the limit, and expose the high part.
    always_comb begin
        cand     = acc_s >>> r_amt;
        do_round = acc[rb_idx] && (cand < POS_MAX);
        cand_r   = cand + ACC_W'(do_round);
        upper    = cand_r >>> (OUT_W - 1);
        low_word = cand_r[OUT_W-1:0];
    end

endmodule

// File: rtl/acc_cut_scale_path.sv
// Module: acc_cut_scale_path
// Window path for cut points of OUT_W and above. No bits are dropped,
// so there is no rounding. The low word is the accumulator shifted left,
// and the overflow part is the accumulator shifted right so that only
// the bits above the window remain. Outputs are meaningful only when the
// cut point is at least OUT_W.
module acc_cut_scale_path #(
    parameter int ACC_W = 64,
    parameter int OUT_W = 32,
    parameter int CUT_W = 7
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [CUT_W-2:0] cut_pos,
    output logic [OUT_W-1:0] low_word,
    output logic [ACC_W-1:0] upper
);
    localparam int SH_W = $clog2(ACC_W);

    logic                    active;
    logic [SH_W-1:0]         l_amt;
    logic [SH_W-1:0]         u_amt;
    logic signed [ACC_W-1:0] acc_s;

    assign acc_s  = acc;
    assign active = int'(cut_pos) >= OUT_W;

    // Left and right shift distances for this cut point.
    always_comb begin
        if (active) begin
            l_amt = SH_W'(int'(cut_pos) - OUT_W);
            u_amt = SH_W'(ACC_W - 1 - int'(cut_pos));
        end else begin
            l_amt = '0;
            u_amt = '0;
        end
    end

    // Scaled low word and the bits above the window.
    always_comb begin
        low_word = OUT_W'(acc << l_amt);
        upper    = acc_s >>> u_amt;
    end

endmodule

// File: rtl/acc_cut_saturate.sv
// Module: acc_cut_saturate
// Picks the active window path and clamps its result. The overflow part
// must be 0 or -1 for the low word to stand unchanged. Anything above 0
// clamps to the positive limit; anything below -1 clamps to the negative
// limit.
module acc_cut_saturate
    import acc_cut_pkg::*;
#(
    parameter int ACC_W = 64,
    parameter int OUT_W = 32
) (
    input  logic             sel_round,
    input  logic [OUT_W-1:0] rnd_low,
    input  logic [ACC_W-1:0] rnd_upper,
    input  logic [OUT_W-1:0] scl_low,
    input  logic [ACC_W-1:0] scl_upper,
    output logic [OUT_W-1:0] word
);
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] low;
    logic [ACC_W-1:0] upper;
    sat_class_e       cls;

    // Path selection by cut point range.
    always_comb begin
        low   = sel_round ? rnd_low   : scl_low;
        upper = sel_round ? rnd_upper : scl_upper;
    end

    // Classify the overflow part by sign and magnitude.
    always_comb begin
        if (!upper[ACC_W-1] && (|upper[ACC_W-2:0])) begin
            cls = SAT_POS;
        end else if (upper[ACC_W-1] && !(&upper[ACC_W-2:0])) begin
            cls = SAT_NEG;
        end else begin
            cls = SAT_NONE;
        end
    end

    // Final clamped word.
    always_comb begin
        unique case (cls)
            SAT_POS: word = POS_LIM;
            SAT_NEG: word = NEG_LIM;
            default: word = low;
        endcase
    end

endmodule

// File: rtl/acc_cut_round.sv
// Module: acc_cut_round (top)
// Single-stage accumulator window extractor. Decodes the cut point,
// computes both window paths in parallel, clamps the chosen one, and
// registers the word together with a valid flag. Reset is synchronous
// and active low. The result register holds when no request arrives.
module acc_cut_round
    import acc_cut_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OUT_W = OUT_W_DEF,
    parameter int CUT_W = CUT_W_DEF,
    parameter int OP_W  = OP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [OP_W-1:0]  cut_op,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_word
);
    logic [CUT_W-2:0] cut_pos;
    logic [ACC_W-1:0] acc_adj;
    logic [OUT_W-1:0] rnd_low;
    logic [ACC_W-1:0] rnd_upper;
    logic [OUT_W-1:0] scl_low;
    logic [ACC_W-1:0] scl_upper;
    logic             sel_round;
    logic [OUT_W-1:0] next_word;

    acc_cut_decode #(.ACC_W(ACC_W), .OP_W(OP_W), .CUT_W(CUT_W)) u_decode (
        .cut_op  (cut_op),
        .acc_in  (acc_in),
        .cut_pos (cut_pos),
        .acc_adj (acc_adj)
    );

    acc_cut_round_path #(.ACC_W(ACC_W), .OUT_W(OUT_W), .CUT_W(CUT_W)) u_round (
        .acc      (acc_adj),
        .cut_pos  (cut_pos),
        .low_word (rnd_low),
        .upper    (rnd_upper)
    );

    acc_cut_scale_path #(.ACC_W(ACC_W), .OUT_W(OUT_W), .CUT_W(CUT_W)) u_scale (
        .acc      (acc_adj),
        .cut_pos  (cut_pos),
        .low_word (scl_low),
        .upper    (scl_upper)
    );

    assign sel_round = int'(cut_pos) < OUT_W;

    acc_cut_saturate #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_sat (
        .sel_round (sel_round),
        .rnd_low   (rnd_low),
        .rnd_upper (rnd_upper),
        .scl_low   (scl_low),
        .scl_upper (scl_upper),
        .word      (next_word)
    );

    // Output register: capture on request, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= next_word;
            end
        end
    end

endmodule

// File: rtl/acc_cut_round_chk.sv
// Module: acc_cut_round_chk
// Port-level temporal checks for acc_cut_round, attached with bind.
module acc_cut_round_chk #(
    parameter int ACC_W = 64,
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [ACC_W-1:0] acc_in,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_word
);
    // R1: a request produces a valid flag one cycle later
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no request, no valid flag
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: result holds without a request
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R9: zero accumulator gives zero
    a_r9_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_in == '0) |=> (out_word == '0));

    // R10: non-negative input never yields a negative word
    a_r10_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_in[ACC_W-1]) |=> !out_word[OUT_W-1]);

    // R10: negative input never yields a positive word
    a_r10_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_in[ACC_W-1]) |=> (out_word[OUT_W-1] || out_word == '0));

endmodule

bind acc_cut_round acc_cut_round_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_in    (acc_in),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/acc_cut_round_tb.sv
// Bench for acc_cut_round: behavioural 128-bit reference, compared each cycle.
module acc_cut_round_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] acc_in = '0;
    logic [31:0] cut_op = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int          vectors = 0;
    int          miscompares = 0;
    logic [31:0] exp_word = '0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cut_round u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .acc_in    (acc_in),
        .cut_op    (cut_op),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // Reference: 128-bit sign extension, window, half-up rounding, clamp.
    function automatic logic [31:0] ref_cut(input logic [63:0] acc, input logic [31:0] op);
        logic signed [127:0] a;
        logic signed [127:0] t;
        int c;
        a = {{64{acc[63]}}, acc};
        c = int'($signed(op[6:0]));
        if (c < 0) begin
            a = a >>> ((c == -64) ? 63 : -c);
            c = 0;
        end
        if (c < 32) begin
            t = a >>> (32 - c);
            if (a[31 - c] && t < 128'sh7fffffff) t = t + 1;
        end else begin
            t = a <<< (c - 32);
        end
        if (t > 128'sh7fffffff) return 32'h7fffffff;
        if (t < -128'sh80000000) return 32'h80000000;
        return t[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: drive at negedge, check at the following negedge.
    task automatic step(input logic v, input logic [63:0] a, input logic [31:0] op, input string tag);
        in_valid = v;
        acc_in   = a;
        cut_op   = op;
        if (v) exp_word = ref_cut(a, op);
        @(negedge clk);
        check({tag, " valid"}, {31'd0, out_valid}, {31'd0, v});
        check(tag, out_word, exp_word);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // R2: reset state
        check("R2 valid", {31'd0, out_valid}, 32'd0);
        check("R2 word", out_word, 32'd0);
        rst_n = 1'b1;

        // Sweep every cut point over characteristic accumulators.
        for (int c = -64; c < 64; c++) begin
            logic [31:0] lo_op;
            lo_op = {25'd0, 7'(c)};
            step(1'b1, 64'd0, lo_op, "R9 zero acc");
            step(1'b1, 64'h7fff_ffff_ffff_ffff, lo_op, "R8 max acc");
            step(1'b1, 64'h8000_0000_0000_0000, lo_op, "R8 min acc");
            step(1'b1, rnd64(), lo_op, (c < 0) ? "R7 negative cut" : "R5 window");
            step(1'b1, {{32{1'b1}}, $urandom}, lo_op, "R10 small negative");
            step(1'b1, rnd64(), {$urandom_range(1, 32'h01ff_ffff), 7'(c)}, "R4 high op bits");
        end

        // Rounding boundaries for each dropping cut point.
        for (int c = 0; c < 32; c++) begin
            logic [63:0] half;
            half = 64'd1 << (31 - c);
            step(1'b1, half, {25'd0, 7'(c)}, "R6 half rounds to one");
            step(1'b1, (64'h7fff_ffff << (32 - c)) | half, {25'd0, 7'(c)}, "R6 round at limit");
            step(1'b1, -half, {25'd0, 7'(c)}, "R6 minus half to zero");
        end

        // Pre-shift at the extreme negative cut.
        step(1'b1, 64'hffff_ffff_ffff_ffff, 32'h0000_0040, "R7 cut -64 all ones");
        step(1'b1, 64'h4000_0000_0000_0000, 32'h0000_0040, "R7 cut -64 positive");
        step(1'b1, 64'h0000_0001_8000_0000, 32'h0000_007f, "R7 cut -1");

        // Idle cycles with changing inputs must hold the word (R3).
        step(1'b1, 64'h0000_1234_5678_9abc, 32'd16, "R5 before idle");
        for (int i = 0; i < 8; i++) step(1'b0, rnd64(), $urandom, "R3 idle hold");

        // Mixed random traffic with gaps (R1).
        for (int i = 0; i < 1500; i++) begin
            logic v;
            v = ($urandom_range(0, 3) != 0);
            step(v, rnd64() >>> $urandom_range(0, 63), $urandom, v ? "R1 random burst" : "R3 random gap");
        end

        // Reset in the middle of traffic (R2).
        step(1'b1, 64'h7fff_0000_0000_0000, 32'd40, "R8 before reset");
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        exp_word = '0;
        check("R2 valid after mid reset", {31'd0, out_valid}, 32'd0);
        check("R2 word after mid reset", out_word, 32'd0);
        rst_n = 1'b1;
        step(1'b1, 64'h0000_0000_8000_0000, 32'd0, "R6 after reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule